// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block follows every instruction through a five-stage in-order pipeline and makes sure that exceptions are taken precisely. It owns the fetch address register. Each staging register, from fetch/decode through memory/writeback, holds a valid bit, the instruction address, its register-write and memory-write intents, and a 3-bit exception code. Detection logic elsewhere in the core reports a fault as a code on a per-stage input during the cycle in which the instruction sits in that stage. The block writes the code into that instruction's record and cancels the instruction's architectural writes.

No exception is acted on until the memory stage. When the instruction in MEM carries a nonzero code, whether recorded earlier or reported in MEM itself, the controller commits in that cycle. It kills that instruction's memory write. The instructions in the three younger stages become bubbles at the next edge. The faulting address and its code are latched into the exception-PC and cause registers, and fetch moves to a fixed handler address. Because commitment happens only in MEM, a fault reported out of program order is still handled in program order. An older instruction already in writeback completes its write normally.

Top module: `exc_pipe_top`

## Requirements
- R1: While reset is asserted and at the first cycle after it, fetchPc equals RESET_PC (default 0x1000), memWriteEn, regWriteEn and excTaken are 0, and epc and causeCode are 0.
- R2: In every cycle that follows a cycle with no commitment, fetchPc is the previous fetchPc plus INSN_BYTES (default 4).
- R3: An instruction that has a nonzero exception code recorded, or reported in MEM, never asserts memWriteEn in MEM or regWriteEn in WB.
- R4: An instruction keeps the first nonzero code reported for it. A code reported in a later stage for the same instruction does not change it.
- R5: Code value 0 means no exception, and codes are 3 bits wide. excTaken is 1 in exactly the cycles in which the valid instruction in MEM has a nonzero code.
- R6: At the edge that ends a commit cycle, epc loads the faulting instruction's PC and causeCode loads its code. Both hold their values otherwise.
- R7: In the cycle after a commit, fetchPc equals HANDLER_PC (default 0x180). Sequential fetch continues from that address.
- R8: The three instructions younger than the faulting one (in EX, ID and IF during the commit cycle) produce no memory write, no register write and no commit.
- R9: An older instruction in WB during a commit cycle still asserts regWriteEn with its own PC on regWritePc.
- R10: When the MEM instruction commits, exceptions reported in the same cycle for younger instructions are discarded. The older fault's PC and code reach epc and causeCode.
- R11: A fetch slot with fetchValid = 0 is a bubble. It ignores all exception inputs as it moves down the pipeline and never writes or commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | The slot fetched at fetchPc holds a real instruction |
| fetchRegWr | input | 1 | The fetched instruction intends to write a register |
| fetchMemWr | input | 1 | The fetched instruction intends to write memory |
| excIf | input | CODE_W | Fault code for the instruction being fetched (0 = none) |
| excId | input | CODE_W | Fault code for the instruction in decode |
| excEx | input | CODE_W | Fault code for the instruction in execute |
| excMem | input | CODE_W | Fault code for the instruction in memory |
| fetchPc | output | PC_W | Current fetch address |
| memWriteEn | output | 1 | Memory write allowed for the MEM instruction |
| memWritePc | output | PC_W | PC of the MEM instruction |
| regWriteEn | output | 1 | Register write allowed for the WB instruction |
| regWritePc | output | PC_W | PC of the WB instruction |
| excTaken | output | 1 | Commit to an exception in this cycle |
| epc | output | PC_W | Saved faulting PC |
| causeCode | output | CODE_W | Saved exception code |

## Verification
Directed sequences separate the cases that the ordering rule must tell apart. One instruction is faulted twice in successive stages, which shows whether the first code is kept. A fault in MEM arrives together with faults in EX and ID, which shows whether the older fault wins and the younger ones vanish. A fault is committed while an older writer sits in WB, which shows whether the older write survives while the three flushed stores are dropped. A bubble is driven with faults in every stage to show that invalid slots are inert. A long seeded random stream of sparse codes, mixed intents and bubbles is then compared cycle by cycle against an instruction-level model built in the bench. The comparison covers fetch address, write enables, commit, exception PC and cause, so it also catches back-to-back and nested commits that the directed cases miss.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // Strobes the control side issues to the datapath in a commit cycle.
  typedef struct packed {
    logic flush;     // younger three staging registers become bubbles
    logic killMem;   // suppress the store of the instruction in MEM
    logic loadEpc;   // capture faulting PC and code
    logic redirect;  // fetch register loads the handler address
  } excStrobes_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              memValid,
  input  logic [CODE_W-1:0] memCode,
  output excStrobes_t       strobes,
  output logic              excTaken
);

  logic commit;

  // The only point at which an exception is acted on is the end of MEM.
  assign commit = memValid && (memCode != '0);

  always_comb begin
    strobes.flush    = commit;
    strobes.killMem  = commit;
    strobes.loadEpc  = commit;
    strobes.redirect = commit;
  end

  assign excTaken = commit;

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              CODE_W     = 3,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180,
  parameter int              INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  excStrobes_t       strobes,
  input  logic              fetchValid,
  input  logic              fetchRegWr,
  input  logic              fetchMemWr,
  input  logic [CODE_W-1:0] excIf,
  input  logic [CODE_W-1:0] excId,
  input  logic [CODE_W-1:0] excEx,
  input  logic [CODE_W-1:0] excMem,
  output logic              memValid,
  output logic [CODE_W-1:0] memCode,
  output logic [PC_W-1:0]   fetchPc,
  output logic              memWriteEn,
  output logic [PC_W-1:0]   memWritePc,
  output logic              regWriteEn,
  output logic [PC_W-1:0]   regWritePc,
  output logic [PC_W-1:0]   epc,
  output logic [CODE_W-1:0] causeCode
);

  // Staging registers: 0 = IF/ID, 1 = ID/EX, 2 = EX/MEM, 3 = MEM/WB
  localparam int NUM_STAGES = 4;
  localparam int MEM_IDX    = NUM_STAGES - 2;
  localparam int WB_IDX     = NUM_STAGES - 1;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSN_BYTES);

  typedef struct packed {
    logic              valid;
    logic [PC_W-1:0]   pc;
    logic [CODE_W-1:0] code;
    logic              regWr;
    logic              memWr;
  } stage_t;

  stage_t            st     [NUM_STAGES];
  stage_t            src    [NUM_STAGES];
  logic [CODE_W-1:0] detCode[NUM_STAGES];
  logic [PC_W-1:0]   pcReg;

  // detCode[k] is the fault reported for the instruction that feeds register k.
  assign detCode[0] = excIf;
  assign detCode[1] = excId;
  assign detCode[2] = excEx;
  assign detCode[3] = excMem;

  // Next contents of every staging register: the earliest code wins, writes die with any code.
  always_comb begin
    stage_t raw;
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (k == 0) begin
        raw.valid = fetchValid;
        raw.pc    = pcReg;
        raw.code  = '0;
        raw.regWr = fetchRegWr;
        raw.memWr = fetchMemWr;
      end else begin
        raw = st[k-1];
      end
      src[k] = raw;
      if (!raw.valid)          src[k].code = '0;
      else if (raw.code != '0) src[k].code = raw.code;
      else                     src[k].code = detCode[k];
      src[k].regWr = raw.valid && raw.regWr && (src[k].code == '0);
      src[k].memWr = raw.valid && raw.memWr && (src[k].code == '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_STAGES; k++) begin
      if (rst) begin
        st[k] <= '0;
      end else if (strobes.flush && (k < WB_IDX)) begin
        st[k] <= '0;
      end else begin
        st[k] <= src[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg     <= RESET_PC;
      epc       <= '0;
      causeCode <= '0;
    end else begin
      pcReg <= strobes.redirect ? HANDLER_PC : (pcReg + PC_STEP);
      if (strobes.loadEpc) begin
        epc       <= st[MEM_IDX].pc;
        causeCode <= src[WB_IDX].code;
      end
    end
  end

  assign memValid   = st[MEM_IDX].valid;
  assign memCode    = src[WB_IDX].code;
  assign fetchPc    = pcReg;
  assign memWriteEn = st[MEM_IDX].valid && st[MEM_IDX].memWr && !strobes.killMem;
  assign memWritePc = st[MEM_IDX].pc;
  assign regWriteEn = st[WB_IDX].valid && st[WB_IDX].regWr;
  assign regWritePc = st[WB_IDX].pc;

  // R2: sequential fetch when no redirect
  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.redirect |=> pcReg == $past(pcReg) + PC_STEP);

  // R3: a store that reaches the port belongs to a fault-free instruction
  assert_store_clean_R3: assert property (@(posedge clk) disable iff (rst)
    memWriteEn |-> (st[MEM_IDX].code == '0) && (excMem == '0));

  // R3: a register write that reaches the port belongs to a fault-free instruction
  assert_wb_clean_R3: assert property (@(posedge clk) disable iff (rst)
    regWriteEn |-> st[WB_IDX].code == '0);

  // R6: faulting PC and a nonzero cause are captured at the commit edge
  assert_epc_load_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.loadEpc |=> (epc == $past(st[MEM_IDX].pc)) && (causeCode != '0));

  // R7: fetch moves to the handler right after a commit
  assert_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.redirect |=> pcReg == HANDLER_PC);

  // R8: the three younger slots are bubbles after a commit
  assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.flush |=> !st[0].valid && !st[1].valid && !st[MEM_IDX].valid);

endmodule

// File: rtl/exc_pipe_top.sv
module exc_pipe_top
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              CODE_W     = 3,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180,
  parameter int              INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchValid,
  input  logic              fetchRegWr,
  input  logic              fetchMemWr,
  input  logic [CODE_W-1:0] excIf,
  input  logic [CODE_W-1:0] excId,
  input  logic [CODE_W-1:0] excEx,
  input  logic [CODE_W-1:0] excMem,
  output logic [PC_W-1:0]   fetchPc,
  output logic              memWriteEn,
  output logic [PC_W-1:0]   memWritePc,
  output logic              regWriteEn,
  output logic [PC_W-1:0]   regWritePc,
  output logic              excTaken,
  output logic [PC_W-1:0]   epc,
  output logic [CODE_W-1:0] causeCode
);

  excStrobes_t       strobes;
  logic              memValid;
  logic [CODE_W-1:0] memCode;

  exc_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .memValid (memValid),
    .memCode  (memCode),
    .strobes  (strobes),
    .excTaken (excTaken)
  );

  exc_datapath #(
    .PC_W       (PC_W),
    .CODE_W     (CODE_W),
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC),
    .INSN_BYTES (INSN_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .fetchValid (fetchValid),
    .fetchRegWr (fetchRegWr),
    .fetchMemWr (fetchMemWr),
    .excIf      (excIf),
    .excId      (excId),
    .excEx      (excEx),
    .excMem     (excMem),
    .memValid   (memValid),
    .memCode    (memCode),
    .fetchPc    (fetchPc),
    .memWriteEn (memWriteEn),
    .memWritePc (memWritePc),
    .regWriteEn (regWriteEn),
    .regWritePc (regWritePc),
    .epc        (epc),
    .causeCode  (causeCode)
  );

endmodule

// File: tb/exc_pipe_top_bench.sv
module exc_pipe_top_bench;

  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] HND_PC = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetchValid = 1'b0, fetchRegWr = 1'b0, fetchMemWr = 1'b0;
  logic [2:0]  excIf = '0, excId = '0, excEx = '0, excMem = '0;
  logic [31:0] fetchPc, memWritePc, regWritePc, epc;
  logic        memWriteEn, regWriteEn, excTaken;
  logic [2:0]  causeCode;

  int nChecks = 0;
  int nFail   = 0;

  // Instruction-level model: slot 0 = decode ... slot 3 = writeback
  logic        mV  [4];
  logic [31:0] mPc [4];
  logic [2:0]  mCode[4];
  logic        mRw [4];
  logic        mMw [4];
  logic [31:0] mFetch, mEpc;
  logic [2:0]  mCause;

  always #2 clk = ~clk;  // 250 MHz

  exc_pipe_top u_exc_pipe_top (
    .clk(clk), .rst(rst),
    .fetchValid(fetchValid), .fetchRegWr(fetchRegWr), .fetchMemWr(fetchMemWr),
    .excIf(excIf), .excId(excId), .excEx(excEx), .excMem(excMem),
    .fetchPc(fetchPc), .memWriteEn(memWriteEn), .memWritePc(memWritePc),
    .regWriteEn(regWriteEn), .regWritePc(regWritePc), .excTaken(excTaken),
    .epc(epc), .causeCode(causeCode)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // First code reported for a real instruction is the one that stays.
  function automatic logic [2:0] pick(input logic v, input logic [2:0] old, input logic [2:0] det);
    if (!v) return 3'd0;
    return (old != 3'd0) ? old : det;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 4; k++) begin
      mV[k] = 1'b0; mPc[k] = '0; mCode[k] = '0; mRw[k] = 1'b0; mMw[k] = 1'b0;
    end
    mFetch = RST_PC; mEpc = '0; mCause = '0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    fetchValid = 0; fetchRegWr = 0; fetchMemWr = 0;
    excIf = 0; excId = 0; excEx = 0; excMem = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(fetchPc, RST_PC, "R1 reset fetchPc");
    chk({31'd0, memWriteEn}, 0, "R1 reset memWriteEn");
    chk({31'd0, regWriteEn}, 0, "R1 reset regWriteEn");
    chk({31'd0, excTaken}, 0, "R1 reset excTaken");
    chk(epc, 0, "R1 reset epc");
    chk({29'd0, causeCode}, 0, "R1 reset causeCode");
    @(posedge clk);
    #1 rst = 1'b0;
    modelReset();
  endtask

  // One cycle: drive, compare against the model, then advance the model past the edge.
  task automatic step(input logic fv, input logic rw, input logic mw,
                      input logic [2:0] eIf, input logic [2:0] eId,
                      input logic [2:0] eEx, input logic [2:0] eMem);
    logic [2:0] memC;
    logic       take;
    logic       expMw, expRw;
    @(negedge clk);
    fetchValid = fv; fetchRegWr = rw; fetchMemWr = mw;
    excIf = eIf; excId = eId; excEx = eEx; excMem = eMem;
    #1;
    memC  = pick(mV[2], mCode[2], eMem);
    take  = mV[2] && (memC != 0);
    expMw = mV[2] && mMw[2] && (memC == 0);
    expRw = mV[3] && mRw[3] && (mCode[3] == 0);
    chk(fetchPc, mFetch, "R2/R7 fetch address");
    chk(epc, mEpc, "R6 epc");
    chk({29'd0, causeCode}, {29'd0, mCause}, "R6 causeCode");
    chk({31'd0, excTaken}, {31'd0, take}, "R5/R10 commit");
    chk({31'd0, memWriteEn}, {31'd0, expMw}, "R3/R8 memWriteEn");
    chk({31'd0, regWriteEn}, {31'd0, expRw}, "R3/R9 regWriteEn");
    if (expMw) chk(memWritePc, mPc[2], "R3 memWritePc");
    if (expRw) chk(regWritePc, mPc[3], "R9 regWritePc");
    // advance
    mV[3] = mV[2]; mPc[3] = mPc[2]; mCode[3] = memC; mRw[3] = mRw[2]; mMw[3] = mMw[2];
    if (take) begin
      mEpc = mPc[2]; mCause = memC; mFetch = HND_PC;
      for (int k = 0; k < 3; k++) begin
        mV[k] = 1'b0; mPc[k] = '0; mCode[k] = '0; mRw[k] = 1'b0; mMw[k] = 1'b0;
      end
    end else begin
      mV[2] = mV[1]; mPc[2] = mPc[1]; mCode[2] = pick(mV[1], mCode[1], eEx);
      mRw[2] = mRw[1]; mMw[2] = mMw[1];
      mV[1] = mV[0]; mPc[1] = mPc[0]; mCode[1] = pick(mV[0], mCode[0], eId);
      mRw[1] = mRw[0]; mMw[1] = mMw[0];
      mV[0] = fv; mPc[0] = mFetch; mCode[0] = fv ? eIf : 3'd0;
      mRw[0] = rw; mMw[0] = mw;
      mFetch = mFetch + 32'd4;
    end
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();

    // R4: decode fault 3, then execute fault 5 on the same instruction
    doReset();
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 3, 0, 0);
    step(1, 0, 0, 0, 0, 5, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk({31'd0, excTaken}, 1, "R5 commit in MEM");
    chk({31'd0, memWriteEn}, 0, "R3 faulting store cancelled");
    step(1, 0, 0, 0, 0, 0, 0);
    chk({29'd0, causeCode}, 3, "R4 first code kept");
    chk(epc, RST_PC, "R6 faulting PC saved");
    chk(fetchPc, HND_PC, "R7 redirect to handler");
    chk({31'd0, regWriteEn}, 0, "R3 faulting register write cancelled");
    step(1, 0, 0, 0, 0, 0, 0);
    chk(fetchPc, HND_PC + 32'd4, "R7 sequential after handler");

    // R9 and R8: fault on second instruction while first sits in WB
    doReset();
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 2);
    chk({31'd0, excTaken}, 1, "R9 commit of second instruction");
    chk({31'd0, regWriteEn}, 1, "R9 older write completes");
    chk(regWritePc, RST_PC, "R9 older write PC");
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1, 0, 0, 0, 0);
      chk({31'd0, memWriteEn}, 0, "R8 flushed store");
      chk({31'd0, excTaken}, 0, "R8 no commit from flushed slot");
      if (i > 0) chk({31'd0, regWriteEn}, 0, "R8 flushed register write");
    end
    step(1, 1, 1, 0, 0, 0, 0);
    chk({31'd0, memWriteEn}, 1, "R7 handler stream store");
    chk(memWritePc, HND_PC, "R7 handler stream PC");

    // R10: MEM fault 1 together with EX fault 6 and ID fault 4
    doReset();
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 4, 6, 1);
    chk({31'd0, excTaken}, 1, "R10 older commits");
    step(1, 0, 0, 0, 0, 0, 0);
    chk({29'd0, causeCode}, 1, "R10 older cause wins");
    chk(epc, RST_PC, "R10 older PC wins");
    chk({31'd0, excTaken}, 0, "R10 younger fault discarded");
    step(1, 0, 0, 0, 0, 0, 0);
    chk({31'd0, excTaken}, 0, "R10 younger fault discarded later");

    // R11: a bubble with faults reported in every stage
    doReset();
    step(0, 1, 1, 7, 0, 0, 0);
    step(1, 0, 0, 0, 5, 0, 0);
    step(1, 0, 0, 0, 0, 5, 0);
    step(1, 0, 0, 0, 0, 0, 5);
    chk({31'd0, excTaken}, 0, "R11 bubble never commits");
    chk({31'd0, memWriteEn}, 0, "R11 bubble never stores");
    step(1, 0, 0, 0, 0, 0, 0);
    chk({31'd0, regWriteEn}, 0, "R11 bubble never writes register");
    chk(fetchPc, RST_PC + 32'd16, "R11 no redirect from bubble");

    // Seeded random stream checked cycle by cycle against the model
    doReset();
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] c[4];
      for (int j = 0; j < 4; j++)
        c[j] = (($urandom % 24) == 0) ? 3'(($urandom % 7) + 1) : 3'd0;
      step(($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 3 == 0,
           c[0], c[1], c[2], c[3]);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule